// File: doc/BRIEF.md
# Converter Host Bus and Status Register

This block is the parallel host port of a 12-bit data converter. The host selects it with an active-low chip select and uses separate active-low read and write strobes. Two select lines steer each access. The register-select line picks between the conversion result and an 8-bit control/status register. The byte-select line picks the upper or lower part of the result, or enables register access.

The control/status register holds three writable mode bits: the output mode, the role of the trigger pin and power-down. It also holds a sticky power-fail flag and live copies of the calibration-active, calibration-overflow and busy inputs. The output mode sets how the host sees the result. In transparent mode the result input is passed straight through. In latched mode the block captures a snapshot on each conversion-done pulse and shows that snapshot to the host.

The data bus is split into an input byte, an output byte and an output-enable for an external tri-state pad.

Top module: `conv_host_bus`

## Requirements
- R1: The output enable `data_oe_o` is high only while both `cs_ni` and `rd_ni` are low. While it is low, `data_o` is 0.
- R2: A read with `sfr_i`=1 and `hbe_i`=1 returns the register with this layout: bit0 output mode, bit1 calibration active, bit2 trigger role, bit3 power-down, bit4 reserved, bit5 power fail, bit6 calibration overflow, bit7 busy.
- R3: A write happens on a clock edge while `cs_ni`=0, `wr_ni`=0, `sfr_i`=1 and `hbe_i`=1. It loads bit0 (1 = latched), bit2 (1 = sample-hold control) and bit3 (1 = powered down) from `data_i`. These bits also drive `latched_mode_o`, `trig_hold_o` and `power_down_o`.
- R4: After reset the register reads 0x08: transparent mode, trigger as calibration start, powered down, power fail clear.
- R5: Bits 1, 6 and 7 read back the current levels of `cal_busy_i`, `cal_ovf_i` and `busy_i`.
- R6: Bit 4 always reads 0, and writing 1 to it has no effect.
- R7: The power-fail flag (bit 5) is set one cycle after `pwr_fail_i` is high and then stays set. A register write with `data_i[5]`=0 clears it. Writing 1 to bit 5 does nothing. If a set and a clear happen in the same cycle, the set wins.
- R8: A read with `sfr_i`=0 and `hbe_i`=1 returns result bits 11..8 in bits 3..0, with bits 7..4 at 0. A read with `sfr_i`=0 and `hbe_i`=0 returns result bits 7..0.
- R9: In transparent mode (bit0=0), result reads follow `result_i` in the same cycle.
- R10: In latched mode (bit0=1), result reads return the value that `result_i` had at the last clock edge with `conv_done_i`=1. That value is held until the next such edge.
- R11: A write strobe with `cs_ni`=1, with `sfr_i`=0 or with `hbe_i`=0 leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| hbe_i | input | 1 | Byte select: high byte / register enable |
| sfr_i | input | 1 | Register select: 1 = status register, 0 = result |
| data_i | input | 8 | Host write data |
| data_o | output | 8 | Host read data |
| data_oe_o | output | 1 | Tri-state enable for the data pads |
| result_i | input | 12 | Conversion result from the converter core |
| conv_done_i | input | 1 | One-cycle pulse at the end of a conversion |
| cal_busy_i | input | 1 | Calibration in progress |
| cal_ovf_i | input | 1 | Calibration overflow occurred |
| busy_i | input | 1 | Conversion or calibration running |
| pwr_fail_i | input | 1 | Supply failure detected |
| latched_mode_o | output | 1 | Register bit 0 |
| trig_hold_o | output | 1 | Register bit 2 |
| power_down_o | output | 1 | Register bit 3 |

## Verification
The assertions assume that the host strobes and the select lines are synchronous to `clk_i`. They also assume the select lines stay steady for the whole of an access, so that each write lands on exactly one defined edge. The stimulus changes every host input one time unit after a rising edge and holds each strobe for a full clock period. `conv_done_i` and `pwr_fail_i` are driven as single-cycle pulses. Reads with `sfr_i`=1 and `hbe_i`=0 return an undefined byte, so the stimulus never issues them.

// File: rtl/conv_bus_pkg.sv
package conv_bus_pkg;
  localparam int unsigned DATA_W = 8;

  // status register bit positions (host software decodes these)
  localparam int unsigned B_MODE = 0;
  localparam int unsigned B_CAL  = 1;
  localparam int unsigned B_TRIG = 2;
  localparam int unsigned B_PD   = 3;
  localparam int unsigned B_RSV  = 4;
  localparam int unsigned B_PF   = 5;
  localparam int unsigned B_OVF  = 6;
  localparam int unsigned B_BUSY = 7;

  typedef struct packed {
    logic power_down;
    logic trig_hold;
    logic latched;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{power_down: 1'b1, trig_hold: 1'b0, latched: 1'b0};
endpackage

// File: rtl/cb_strobe.sv
module cb_strobe (
  input  logic cs_ni,
  input  logic rd_ni,
  input  logic wr_ni,
  input  logic sfr_i,
  input  logic hbe_i,
  output logic rd_act_o,
  output logic sfr_wr_o
);
  logic wr_act;

  // NOR of chip select with each strobe
  assign rd_act_o = ~(cs_ni | rd_ni);
  assign wr_act   = ~(cs_ni | wr_ni);
  assign sfr_wr_o = wr_act & sfr_i & hbe_i;
endmodule

// File: rtl/cb_sfr.sv
module cb_sfr
  import conv_bus_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sfr_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              cal_busy_i,
  input  logic              cal_ovf_i,
  input  logic              busy_i,
  input  logic              pwr_fail_i,
  output logic [DATA_W-1:0] sfr_o,
  output ctrl_t             ctrl_o,
  output logic              pf_flag_o
);
  ctrl_t ctrl_q;
  logic  pf_q;
  logic  wdata_unused;

  assign wdata_unused = ^{wdata_i[B_BUSY], wdata_i[B_OVF], wdata_i[B_RSV], wdata_i[B_CAL]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
    end else if (sfr_wr_i) begin
      ctrl_q.latched    <= wdata_i[B_MODE];
      ctrl_q.trig_hold  <= wdata_i[B_TRIG];
      ctrl_q.power_down <= wdata_i[B_PD];
    end
  end

  // sticky; a new failure outranks a software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           pf_q <= 1'b0;
    else if (pwr_fail_i)                   pf_q <= 1'b1;
    else if (sfr_wr_i && !wdata_i[B_PF])   pf_q <= 1'b0;
  end

  always_comb begin
    sfr_o         = '0;
    sfr_o[B_MODE] = ctrl_q.latched;
    sfr_o[B_CAL]  = cal_busy_i;
    sfr_o[B_TRIG] = ctrl_q.trig_hold;
    sfr_o[B_PD]   = ctrl_q.power_down;
    sfr_o[B_RSV]  = 1'b0;
    sfr_o[B_PF]   = pf_q;
    sfr_o[B_OVF]  = cal_ovf_i;
    sfr_o[B_BUSY] = busy_i;
  end

  assign ctrl_o    = ctrl_q;
  assign pf_flag_o = pf_q;
endmodule

// File: rtl/cb_result.sv
module cb_result #(
  parameter int unsigned RES_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             latched_i,
  input  logic             conv_done_i,
  input  logic [RES_W-1:0] result_i,
  output logic [RES_W-1:0] result_o,
  output logic [RES_W-1:0] held_o
);
  logic [RES_W-1:0] held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          held_q <= '0;
    else if (conv_done_i) held_q <= result_i;
  end

  assign result_o = latched_i ? held_q : result_i;
  assign held_o   = held_q;
endmodule

// File: rtl/cb_rdmux.sv
module cb_rdmux
  import conv_bus_pkg::*;
#(
  parameter int unsigned RES_W = 12
) (
  input  logic              rd_act_i,
  input  logic              sfr_i,
  input  logic              hbe_i,
  input  logic [DATA_W-1:0] sfr_i_data,
  input  logic [RES_W-1:0]  result_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  localparam int unsigned HI_W = RES_W - DATA_W;

  logic [DATA_W-1:0] hi_byte, lo_byte, sel;

  generate
    if (HI_W == DATA_W) begin : g_full_hi
      assign hi_byte = result_i[RES_W-1 -: HI_W];
    end else begin : g_pad_hi
      assign hi_byte = {{(DATA_W-HI_W){1'b0}}, result_i[RES_W-1 -: HI_W]};
    end
  endgenerate

  assign lo_byte = result_i[DATA_W-1:0];

  always_comb begin
    unique case ({sfr_i, hbe_i})
      2'b11:   sel = sfr_i_data;
      2'b10:   sel = '0;  // undefined access, returns zero
      2'b01:   sel = hi_byte;
      default: sel = lo_byte;
    endcase
  end

  assign data_oe_o = rd_act_i;
  assign data_o    = rd_act_i ? sel : '0;
endmodule

// File: rtl/conv_host_bus.sv
module conv_host_bus
  import conv_bus_pkg::*;
#(
  parameter int unsigned RES_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic              hbe_i,
  input  logic              sfr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  input  logic [RES_W-1:0]  result_i,
  input  logic              conv_done_i,
  input  logic              cal_busy_i,
  input  logic              cal_ovf_i,
  input  logic              busy_i,
  input  logic              pwr_fail_i,
  output logic              latched_mode_o,
  output logic              trig_hold_o,
  output logic              power_down_o
);
  logic              rd_act, sfr_wr, pf_flag;
  logic [DATA_W-1:0] sfr_data;
  logic [RES_W-1:0]  res_view, held_res;
  ctrl_t             ctrl;

  cb_strobe i_strobe (
    .cs_ni    (cs_ni),
    .rd_ni    (rd_ni),
    .wr_ni    (wr_ni),
    .sfr_i    (sfr_i),
    .hbe_i    (hbe_i),
    .rd_act_o (rd_act),
    .sfr_wr_o (sfr_wr)
  );

  cb_sfr i_sfr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sfr_wr_i   (sfr_wr),
    .wdata_i    (data_i),
    .cal_busy_i (cal_busy_i),
    .cal_ovf_i  (cal_ovf_i),
    .busy_i     (busy_i),
    .pwr_fail_i (pwr_fail_i),
    .sfr_o      (sfr_data),
    .ctrl_o     (ctrl),
    .pf_flag_o  (pf_flag)
  );

  cb_result #(.RES_W(RES_W)) i_result (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .latched_i   (ctrl.latched),
    .conv_done_i (conv_done_i),
    .result_i    (result_i),
    .result_o    (res_view),
    .held_o      (held_res)
  );

  cb_rdmux #(.RES_W(RES_W)) i_rdmux (
    .rd_act_i   (rd_act),
    .sfr_i      (sfr_i),
    .hbe_i      (hbe_i),
    .sfr_i_data (sfr_data),
    .result_i   (res_view),
    .data_o     (data_o),
    .data_oe_o  (data_oe_o)
  );

  assign latched_mode_o = ctrl.latched;
  assign trig_hold_o    = ctrl.trig_hold;
  assign power_down_o   = ctrl.power_down;
endmodule

// File: rtl/conv_host_bus_chk.sv
module conv_host_bus_chk #(
  parameter int unsigned RES_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_ni,
  input logic             rd_ni,
  input logic             wr_ni,
  input logic             hbe_i,
  input logic             sfr_i,
  input logic [7:0]       data_i,
  input logic [7:0]       data_o,
  input logic             data_oe_o,
  input logic             conv_done_i,
  input logic             busy_i,
  input logic             pwr_fail_i,
  input logic             latched_mode_o,
  input logic             trig_hold_o,
  input logic             power_down_o,
  input logic             pf_flag,
  input logic [RES_W-1:0] held_res
);
  // R1
  oe_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni || rd_ni) |-> (!data_oe_o && data_o == 8'h00));

  // R3
  mode_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !wr_ni && sfr_i && hbe_i) |=> (latched_mode_o == $past(data_i[0])));

  // R11
  no_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni || wr_ni || !sfr_i || !hbe_i) |=>
      ($stable(latched_mode_o) && $stable(trig_hold_o) && $stable(power_down_o)));

  // R6
  rsv_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && sfr_i && hbe_i) |-> !data_o[4]);

  // R5
  busy_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && sfr_i && hbe_i) |-> (data_o[7] == busy_i));

  // R7
  pf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_fail_i |=> pf_flag);

  // R8
  hi_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && !sfr_i && hbe_i) |-> (data_o[7:4] == 4'h0));

  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conv_done_i |=> $stable(held_res));
endmodule

bind conv_host_bus conv_host_bus_chk #(.RES_W(RES_W)) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cs_ni          (cs_ni),
  .rd_ni          (rd_ni),
  .wr_ni          (wr_ni),
  .hbe_i          (hbe_i),
  .sfr_i          (sfr_i),
  .data_i         (data_i),
  .data_o         (data_o),
  .data_oe_o      (data_oe_o),
  .conv_done_i    (conv_done_i),
  .busy_i         (busy_i),
  .pwr_fail_i     (pwr_fail_i),
  .latched_mode_o (latched_mode_o),
  .trig_hold_o    (trig_hold_o),
  .power_down_o   (power_down_o),
  .pf_flag        (pf_flag),
  .held_res       (held_res)
);

// File: tb/test_conv_host_bus.sv
module test_conv_host_bus;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, hbe = 1'b0, sfr = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic        oe;
  logic [11:0] result = 12'h000;
  logic        done = 1'b0, cal_busy = 1'b0, cal_ovf = 1'b0, busy = 1'b0, pfail = 1'b0;
  logic        lat_o, trig_o, pd_o;

  int checks = 0;
  int fails  = 0;
  logic [7:0] q_exp[$];
  string      q_tag[$];
  logic       rd_pend = 1'b0;

  always #4 clk = ~clk;

  conv_host_bus i_conv_host_bus (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rd_ni(rd_n), .wr_ni(wr_n),
    .hbe_i(hbe), .sfr_i(sfr), .data_i(wdata), .data_o(rdata), .data_oe_o(oe),
    .result_i(result), .conv_done_i(done), .cal_busy_i(cal_busy),
    .cal_ovf_i(cal_ovf), .busy_i(busy), .pwr_fail_i(pfail),
    .latched_mode_o(lat_o), .trig_hold_o(trig_o), .power_down_o(pd_o)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected bytes while a read is in progress
  always @(negedge clk) begin
    if (rd_pend && q_exp.size() > 0) begin
      logic [7:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      check({t, " oe"}, {7'b0, oe}, 8'h01);
      check(t, rdata, e);
    end
  end

  task automatic rd_chk(input logic s, input logic h, input logic [7:0] exp, input string tag);
    @(posedge clk); #1;
    q_exp.push_back(exp);
    q_tag.push_back(tag);
    sfr = s; hbe = h; cs_n = 1'b0; rd_n = 1'b0; rd_pend = 1'b1;
    @(posedge clk); #1;
    cs_n = 1'b1; rd_n = 1'b1; rd_pend = 1'b0;
  endtask

  task automatic wr_reg(input logic s, input logic h, input logic c, input logic [7:0] d);
    @(posedge clk); #1;
    sfr = s; hbe = h; cs_n = c; wr_n = 1'b0; wdata = d;
    @(posedge clk); #1;
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R4 latched_mode_o", {7'b0, lat_o}, 8'h00);
    check("R4 power_down_o", {7'b0, pd_o}, 8'h01);
    check("R1 idle oe", {7'b0, oe}, 8'h00);
    rd_chk(1, 1, 8'h08, "R4 reset register");

    // rd low with cs high: bus stays off
    @(posedge clk); #1 rd_n = 1'b0; sfr = 1'b1; hbe = 1'b1;
    @(negedge clk);
    check("R1 cs high oe", {7'b0, oe}, 8'h00);
    check("R1 cs high data", rdata, 8'h00);
    @(posedge clk); #1 rd_n = 1'b1;

    cal_busy = 1'b1; cal_ovf = 1'b1; busy = 1'b1;
    rd_chk(1, 1, 8'hCA, "R5 R2 flags set");
    cal_busy = 1'b0; cal_ovf = 1'b0;
    rd_chk(1, 1, 8'h88, "R5 only busy");
    busy = 1'b0;

    wr_reg(1, 1, 0, 8'hFF);
    @(negedge clk);
    check("R3 latched_mode_o", {7'b0, lat_o}, 8'h01);
    check("R3 trig_hold_o", {7'b0, trig_o}, 8'h01);
    rd_chk(1, 1, 8'h0D, "R3 R6 write ff");
    wr_reg(1, 1, 0, 8'h00);
    @(negedge clk);
    check("R3 power_down_o", {7'b0, pd_o}, 8'h00);
    rd_chk(1, 1, 8'h00, "R3 write 00");

    wr_reg(0, 1, 0, 8'hFF);
    rd_chk(1, 1, 8'h00, "R11 sfr low write");
    wr_reg(1, 0, 0, 8'hFF);
    rd_chk(1, 1, 8'h00, "R11 hbe low write");
    wr_reg(1, 1, 1, 8'hFF);
    rd_chk(1, 1, 8'h00, "R11 cs high write");
    wr_reg(1, 1, 0, 8'h10);
    rd_chk(1, 1, 8'h00, "R6 write reserved bit");

    // sticky power fail
    @(posedge clk); #1 pfail = 1'b1;
    @(posedge clk); #1 pfail = 1'b0;
    rd_chk(1, 1, 8'h20, "R7 pf set");
    repeat (3) @(posedge clk);
    rd_chk(1, 1, 8'h20, "R7 pf sticky");
    wr_reg(1, 1, 0, 8'h20);
    rd_chk(1, 1, 8'h20, "R7 write 1 no effect");
    wr_reg(1, 1, 0, 8'h00);
    rd_chk(1, 1, 8'h00, "R7 cleared");
    @(posedge clk); #1;
    sfr = 1'b1; hbe = 1'b1; cs_n = 1'b0; wr_n = 1'b0; wdata = 8'h00; pfail = 1'b1;
    @(posedge clk); #1;
    cs_n = 1'b1; wr_n = 1'b1; pfail = 1'b0;
    rd_chk(1, 1, 8'h20, "R7 set beats clear");
    wr_reg(1, 1, 0, 8'h00);

    // transparent result
    result = 12'hABC;
    rd_chk(0, 1, 8'h0A, "R8 R9 high nibble");
    rd_chk(0, 0, 8'hBC, "R8 R9 low byte");
    result = 12'h123;
    rd_chk(0, 1, 8'h01, "R9 follows high");
    rd_chk(0, 0, 8'h23, "R9 follows low");

    // latched result
    wr_reg(1, 1, 0, 8'h01);
    @(posedge clk); #1 result = 12'h5A7; done = 1'b1;
    @(posedge clk); #1 done = 1'b0; result = 12'hFFF;
    rd_chk(0, 1, 8'h05, "R10 held high");
    rd_chk(0, 0, 8'hA7, "R10 held low");
    @(posedge clk); #1 result = 12'h3C9; done = 1'b1;
    @(posedge clk); #1 done = 1'b0; result = 12'h000;
    rd_chk(0, 1, 8'h03, "R10 new high");
    rd_chk(0, 0, 8'hC9, "R10 new low");
    wr_reg(1, 1, 0, 8'h00);
    rd_chk(0, 0, 8'h00, "R9 back to transparent");

    @(posedge clk);
    @(negedge clk);
    check("R1 queue drained", 8'(q_exp.size()), 8'h00);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule